// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into CAN-style bit timing. A prescaler divides the clock down to a time quantum. A segment sequencer then walks each nominal bit through four segments in a fixed order: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. The block pulses `bit_start` on the first clock of every sync segment so that a transmitter can put out its next bit. It pulses `sample_stb` at the sample point, which is the boundary between phase 1 and phase 2, and presents the sampled receive level on `sample_bit` at the same time.

The receive line carries NRZ data with no clock in it, so the block recovers timing from recessive-to-dominant edges. The line first passes through a two-flop synchronizer. While the bus is idle, an edge hard-synchronizes the bit: the prescaler and the sequencer restart at the beginning of a sync segment. While the bus is busy, an edge resynchronizes the bit, in the manner of a digital PLL. A late edge lengthens phase 1. An early edge shortens phase 2. Either adjustment is capped by the synchronization jump width.

All timing fields are static. Each is encoded as its length minus one. A valid configuration has a total bit length of 8 to 25 quanta and a phase 2 that is at least as long as the jump width.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(cfg_brp+1) clocks, with cfg_brp from 0 to 63. With no edges on `rx_in`, consecutive `bit_start` pulses are tq*(1+P+A+B) clocks apart. Here P = cfg_prop+1, A = cfg_ph1+1 and B = cfg_ph2+1, each from 1 to 8 quanta.
- R2: `sample_stb` is high for exactly one clock. It falls on the first clock of phase 2, which is tq*(1+P+A+X) clocks after the last `bit_start`, where X is the phase 1 extension granted in that bit (0 when there was none).
- R3: `sample_bit` takes the synchronized receive level at the sample point and holds it until the next sample. Its reset value is 1 (recessive).
- R4: `rx_in` passes through two flops. A 1-to-0 transition of `rx_in` acts on the sequencer at the third rising clock edge after the change. A 0-to-1 transition has no effect on timing.
- R5: When `bus_idle` is 1, a falling edge hard-synchronizes the bit in any segment. The prescaler clears, a new sync segment begins, and `bit_start` is high 3 clocks after the `rx_in` change.
- R6: When `bus_idle` is 0, a falling edge seen in quantum p of the bit lengthens phase 1 by min(p, SJW). Quantum p counts from 0 at the sync segment, and this rule covers an edge in the propagation segment or in phase 1. SJW = cfg_sjw+1, from 1 to 4.
- R7: When `bus_idle` is 0, take an edge seen in quantum p of phase 2 and let r = N-p be the quanta left in the bit. If r > SJW, phase 2 is shortened by SJW. Otherwise a new sync segment starts at once, exactly as in R5.
- R8: At most one resynchronization takes place per bit, and later edges in the same bit are ignored. An edge seen during the sync segment causes no adjustment when `bus_idle` is 0.
- R9: While `tx_dominant` is 1, an edge seen in phase 2 causes no resynchronization.
- R10: `bit_start` is a one-clock pulse on the first clock of each sync segment. It is never high in the same clock as `sample_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_brp | input | 6 | Prescaler value; quantum = 2*(cfg_brp+1) clocks |
| cfg_prop | input | 3 | Propagation segment length minus one |
| cfg_ph1 | input | 3 | Phase 1 length minus one |
| cfg_ph2 | input | 3 | Phase 2 length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| bus_idle | input | 1 | 1 selects hard synchronization for edges |
| tx_dominant | input | 1 | This node is sending a dominant bit |
| rx_in | input | 1 | Asynchronous receive line (1 = recessive) |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Receive level captured at the sample point |
| bit_start | output | 1 | One-clock pulse on the first clock of a bit |

## Verification
The bench builds the block with its default widths: a 6-bit prescaler field, 3-bit segment fields and a 2-bit jump width, so that every segment length from 1 to 8 and every jump width from 1 to 4 can be reached. The prescaler is kept at 0 to 2 so that many bits fit in a short run. Within one bit, edges are placed at every position: the sync quantum, the propagation segment, phase 1, phase 2 where the remaining length exceeds the jump width, and phase 2 where it does not. This covers capped and uncapped extension, shortening, and the immediate restart.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_tick
);
  localparam int CNT_W = BRP_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // quantum = 2*(brp+1) clocks -> terminal count 2*brp+1
  assign lim     = {brp, 1'b1};
  assign tq_tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (tq_tick) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_lvl,
  output logic rx_fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], rx_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rx_lvl  = sync_q[STAGES-1];
  assign rx_fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/cbt_seg_ctrl.sv
module cbt_seg_ctrl
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_tick,
  input  logic             rx_fall,
  input  logic             rx_lvl,
  input  logic             bus_idle,
  input  logic             tx_dominant,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  output logic             restart,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  localparam int LEN_W = SEG_W + 2;

  seg_e             seg;
  logic [LEN_W-1:0] q, ext, shr;
  logic             resynced;

  logic [LEN_W-1:0] prop_len, sjw_len, e_late, r_early, ext_late;
  logic [LEN_W-1:0] ext_eff, shr_eff, seg_len;
  logic             resync_ok, late_ev, early_ev, shrink_ev, hard_ev;
  logic             last_q, end_bit, sample_now;

  always_comb begin
    prop_len  = LEN_W'(cfg_prop) + 1'b1;
    sjw_len   = LEN_W'(cfg_sjw) + 1'b1;
    resync_ok = rx_fall && !bus_idle && !resynced;
    late_ev   = resync_ok && (seg == SEG_PROP || seg == SEG_PH1);
    early_ev  = resync_ok && (seg == SEG_PH2) && !tx_dominant;
    hard_ev   = rx_fall && bus_idle;
    e_late    = (seg == SEG_PROP) ? q + 1'b1 : prop_len + q + 1'b1;
    ext_late  = (e_late > sjw_len) ? sjw_len : e_late;
    ext_eff   = late_ev ? ext_late : ext;
    r_early   = LEN_W'(cfg_ph2) + 1'b1 - shr - q;
    shrink_ev = early_ev && (r_early > sjw_len);
    shr_eff   = shrink_ev ? sjw_len : shr;
    restart   = hard_ev || (early_ev && (r_early <= sjw_len));
    case (seg)
      SEG_SYNC: seg_len = LEN_W'(1);
      SEG_PROP: seg_len = prop_len;
      SEG_PH1:  seg_len = LEN_W'(cfg_ph1) + 1'b1 + ext_eff;
      default:  seg_len = LEN_W'(cfg_ph2) + 1'b1 - shr_eff;
    endcase
    last_q     = (q == seg_len - 1'b1);
    end_bit    = tq_tick && (seg == SEG_PH2) && last_q && !restart;
    sample_now = tq_tick && (seg == SEG_PH1) && last_q && !restart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg        <= SEG_SYNC;
      q          <= '0;
      ext        <= '0;
      shr        <= '0;
      resynced   <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      bit_start  <= 1'b0;
    end else begin
      bit_start  <= restart || end_bit;
      sample_stb <= sample_now;
      if (sample_now) sample_bit <= rx_lvl;
      if (restart) begin
        seg      <= SEG_SYNC;
        q        <= '0;
        ext      <= '0;
        shr      <= '0;
        resynced <= 1'b0;
      end else begin
        if (late_ev) begin
          ext      <= ext_late;
          resynced <= 1'b1;
        end
        if (shrink_ev) begin
          shr      <= sjw_len;
          resynced <= 1'b1;
        end
        if (tq_tick) begin
          if (!last_q) begin
            q <= q + 1'b1;
          end else begin
            q <= '0;
            case (seg)
              SEG_SYNC: seg <= SEG_PROP;
              SEG_PROP: seg <= SEG_PH1;
              SEG_PH1:  seg <= SEG_PH2;
              default: begin
                seg      <= SEG_SYNC;
                ext      <= '0;
                shr      <= '0;
                resynced <= 1'b0;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             bus_idle,
  input  logic             tx_dominant,
  input  logic             rx_in,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  logic tq_tick, restart, rx_lvl, rx_fall;

  cbt_prescaler #(.BRP_W(BRP_W)) presc_i (
    .clk(clk), .rst(rst), .clr(restart), .brp(cfg_brp), .tq_tick(tq_tick)
  );

  cbt_rx_sync #(.STAGES(2)) rxs_i (
    .clk(clk), .rst(rst), .rx_in(rx_in), .rx_lvl(rx_lvl), .rx_fall(rx_fall)
  );

  cbt_seg_ctrl #(.SEG_W(SEG_W), .SJW_W(SJW_W)) seq_i (
    .clk(clk), .rst(rst), .tq_tick(tq_tick), .rx_fall(rx_fall), .rx_lvl(rx_lvl),
    .bus_idle(bus_idle), .tx_dominant(tx_dominant), .cfg_prop(cfg_prop),
    .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw), .restart(restart),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_start(bit_start)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [BRP_W-1:0] cfg_brp,
  input logic [SEG_W-1:0] cfg_prop,
  input logic [SEG_W-1:0] cfg_ph1,
  input logic [SEG_W-1:0] cfg_ph2,
  input logic [SJW_W-1:0] cfg_sjw,
  input logic             bus_idle,
  input logic             tx_dominant,
  input logic             rx_in,
  input logic             sample_stb,
  input logic             sample_bit,
  input logic             bit_start
);
  localparam int CW = 16;

  logic [CW-1:0] since_start, tq_clk, min_samp, max_bit;

  always_comb begin
    tq_clk   = (CW'(cfg_brp) + 1'b1) << 1;
    min_samp = tq_clk * (CW'(cfg_prop) + CW'(cfg_ph1) + 3);
    max_bit  = tq_clk * (CW'(cfg_prop) + CW'(cfg_ph1) + CW'(cfg_ph2) + CW'(cfg_sjw) + 5);
  end

  always_ff @(posedge clk) begin
    if (rst)                   since_start <= '0;
    else if (bit_start)        since_start <= CW'(1);
    else if (~&since_start)    since_start <= since_start + 1'b1;
  end

  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);  // R2
  AST_SAMPLE_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> since_start >= min_samp);  // R2
  AST_SAMPLE_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> $stable(sample_bit) || sample_stb);  // R3
  AST_BIT_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    bit_start |-> since_start <= max_bit);  // R6
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(bit_start && sample_stb));  // R10
endmodule

bind can_bit_timer can_bit_timer_chk #(.BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) chk_i (.*);

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cfg_brp = '0;
  logic [2:0] cfg_prop = '0, cfg_ph1 = '0, cfg_ph2 = '0;
  logic [1:0] cfg_sjw = '0;
  logic       bus_idle = 1'b0, tx_dominant = 1'b0, rx_in = 1'b1;
  logic       sample_stb, sample_bit, bit_start;

  int total = 0, bad = 0;
  int tq, P, A, B, S, N;

  always #4 clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rst(rst), .cfg_brp(cfg_brp), .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1),
    .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw), .bus_idle(bus_idle), .tx_dominant(tx_dominant),
    .rx_in(rx_in), .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_start(bit_start)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_interval(input int d, input bit idle, input bit txd);
    int p = (d + 2) / tq;
    if (idle) return d + 3;                          // R5
    if (p == 0) return tq * N;                       // R8 sync segment
    if (p <= P + A) return tq * (N + mn(p, S));      // R6
    if (txd) return tq * N;                          // R9
    if (N - p <= S) return d + 3;                    // R7 restart
    return tq * (N - S);                             // R7 shorten
  endfunction

  function automatic int exp_sample(input int d);
    int p = (d + 2) / tq;
    if (p >= 1 && p <= P + A) return tq * (1 + P + A + mn(p, S));
    return tq * (1 + P + A);
  endfunction

  task automatic configure(input int brp, input int pp, input int aa, input int bb, input int ss);
    @(negedge clk);
    rst = 1'b1; rx_in = 1'b1; bus_idle = 1'b0; tx_dominant = 1'b0;
    cfg_brp = 6'(brp); cfg_prop = 3'(pp - 1); cfg_ph1 = 3'(aa - 1);
    cfg_ph2 = 3'(bb - 1); cfg_sjw = 2'(ss - 1);
    tq = 2 * (brp + 1); P = pp; A = aa; B = bb; S = ss; N = 1 + pp + aa + bb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_bs();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (bit_start) return;
    end
    check("bit_start timeout", 0, 1);
  endtask

  // measure one bit from a bit_start; optional falling edge at state d, second pair at d+4/d2
  task automatic trial(input int d, input int d2, input bit idle, input bit txd,
                       input bit chk_bit, input bit exp_bit);
    int n = 0, ns = -1, sb = -1;
    wait_bs();
    bus_idle = idle; tx_dominant = txd;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      n++;
      if (sample_stb) begin ns = n; sb = int'(sample_bit); end
      if (bit_start) break;
      if (d != 0 && n == d) rx_in = 1'b0;
      if (d2 != 0 && n == d + 4) rx_in = 1'b1;
      if (d2 != 0 && n == d2) rx_in = 1'b0;
    end
    if (d == 0) check("R1 bit period", n, tq * N);
    else        check("R6/R7/R8/R9 bit period", n, exp_interval(d, idle, txd));
    if (!idle)   check("R2 sample offset", ns, (d == 0) ? tq * (1 + P + A) : exp_sample(d));
    if (chk_bit) check("R3 sample_bit", sb, int'(exp_bit));
    bus_idle = 1'b0; tx_dominant = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // reset state
    configure(1, 3, 4, 4, 2);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset bit_start", int'(bit_start), 0);
    check("R2 reset sample_stb", int'(sample_stb), 0);
    check("R3 reset sample_bit", int'(sample_bit), 1);
    rst = 1'b0;
    // directed: tq=4, N=12, SJW=2
    trial(0, 0, 0, 0, 1, 1);          // R1 free run, recessive sample
    trial(2, 0, 0, 0, 0, 0);          // R6 p=1 -> +1
    rx_in = 1'b1;
    trial(26, 0, 0, 0, 0, 0);         // R6 p=7 capped at 2
    rx_in = 1'b1;
    trial(2, 10, 0, 0, 0, 0);         // R8 second edge ignored
    rx_in = 1'b1;
    trial(1, 0, 0, 0, 0, 0);          // R8 edge in sync: no change
    rx_in = 1'b1;
    trial(34, 0, 0, 0, 0, 0);         // R7 shorten
    rx_in = 1'b1;
    trial(34, 0, 0, 1, 0, 0);         // R9 no resync while tx dominant
    rx_in = 1'b1;
    trial(42, 0, 0, 0, 0, 0);         // R7 restart
    rx_in = 1'b1;
    trial(20, 0, 1, 0, 0, 0);         // R5 hard sync
    rx_in = 1'b1;
    trial(5, 0, 1, 0, 0, 0);          // R4 edge latency of 3 clocks via hard sync
    // R3 dominant level sampled, R4 rising edge has no effect
    trial(0, 0, 0, 0, 0, 0);
    trial(0, 0, 0, 0, 0, 0);
    trial(0, 0, 0, 0, 1, 0);
    rx_in = 1'b1;
    trial(0, 0, 0, 0, 1, 1);          // R4 rise: period unchanged
    // R10 pulse width
    wait_bs();
    @(negedge clk);
    check("R10 bit_start one cycle", int'(bit_start), 0);
    // random configurations
    for (int c = 0; c < 10; c++) begin
      int brp, pp, aa, bb, ss;
      do begin
        brp = $urandom % 3; pp = 1 + $urandom % 8; aa = 1 + $urandom % 8;
        bb = 1 + $urandom % 8; ss = 1 + $urandom % 4;
      end while (bb < ss || (1 + pp + aa + bb) < 8 || (1 + pp + aa + bb) > 25);
      configure(brp, pp, aa, bb, ss);
      trial(0, 0, 0, 0, 1, 1);
      for (int t = 0; t < 12; t++) begin
        int d = 1 + ($urandom % (tq * N - 3));
        bit idl = ($urandom % 4) == 0;
        bit txd = $urandom % 2;
        trial(d, 0, idl, txd, 0, 0);
        rx_in = 1'b1;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule